// File: doc/BRIEF.md
# I2C Register-Access Target with Auto-Increment Pointer

This block is an I2C target that lets a bus host read and write a local file of 128 eight-bit registers. Every transfer goes through a stored pointer. After a write-direction address byte, the host sends a pointer byte. That byte names a register and says whether the pointer steps forward after each data byte. Any further bytes in the same write land in the registers the pointer walks over. A read-direction transfer returns register contents from wherever the pointer currently sits.

The pointer survives STOP and repeated START. A host can therefore issue a write that stops right after the pointer byte, and the next read then starts at that register. Two strap inputs set the low two bits of the device address. They are captured once, on the first clock after the internal reset releases.

SCL and SDA are sampled by the system clock through a short synchronizer. SDA is driven open-drain: an enable output pulls the line low and the block never drives it high. Clock stretching, general call and 10-bit addressing are not part of the block.

Top module: `i2c_regfile_target`

## Requirements
- R1: The 7-bit device address is 1001010 XOR {00000, strap1_i, strap0_i}: strap1_i flips address bit 1 and strap0_i flips address bit 0, so both straps low give 1001010.
- R2: The straps are captured once, on the first clock after the internal reset releases; later strap changes do not alter the address the block answers to.
- R3: The first byte after a matching write-direction address is the pointer byte: bits [6:0] are the register number and bit 7 set to 1 enables auto-increment.
- R4: For each byte it accepts (matching address, pointer, write data), the block pulls SDA low (sda_oe_o=1) for the whole ninth SCL clock.
- R5: Each write data byte is stored in the register the pointer names, after which the pointer advances by one if auto-increment is set.
- R6: In a read, each byte is sent MSB first from the register the pointer names, and the pointer then advances if auto-increment is set. A host ACK (SDA low in the ninth clock) requests another byte; a NACK ends driving until the next START or STOP. The pointer carries over between transactions.
- R7: A write that ends with STOP straight after the pointer byte's ACK changes no register and sets the start address of a later read.
- R8: With auto-increment clear, the pointer stays put, so successive data bytes all write, or all read, the same register.
- R9: An advancing pointer wraps from register 0x7F to register 0x00.
- R10: When the address byte does not match, the block leaves SDA released during the ACK clock and for every later bit until the next START.
- R11: sda_oe_o changes only while SCL is low. START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high.
- R12: A repeated START at any point restarts address reception and keeps the stored pointer and auto-increment setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 leaves it released |
| strap0_i | input | 1 | Address strap for device address bit 0 |
| strap1_i | input | 1 | Address strap for device address bit 1 |

## Verification
Each SDA change the block makes follows an SCL falling edge at the pad by the two synchronizer stages plus one edge-detect register, which is three clocks by default. A received byte is written to the register file on the clock after the synchronized eighth rising edge, well inside the ninth bit. The bench drives SDA four clocks after it lowers SCL, so the block's own SDA changes have already settled. It samples SDA for an ACK or a read bit four clocks into the SCL-high phase, when every value the block produced is stable. A watcher on the falling clock edge checks that sda_oe_o never moves while SCL is high.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RXD,
    ST_ACK1,
    ST_ACK2,
    ST_TX,
    ST_MACK,
    ST_IGN
  } eng_state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } byte_kind_t;

endpackage

// File: rtl/i2ct_linesync.sv
module i2ct_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // bit 1 = SCL, bit 0 = SDA; idle bus is high
  logic [1:0] raw;
  logic [1:0] chain [STAGES];
  logic [1:0] line_s;
  logic [1:0] line_p;
  logic       scl_s;
  logic       scl_p;
  logic       sda_p;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 2'b11;
        else        chain[g] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 2'b11;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign line_s = chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_p <= 2'b11;
    else        line_p <= line_s;
  end

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];
  assign scl_p = line_p[1];
  assign sda_p = line_p[0];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2ct_pointer.sv
module i2ct_pointer #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [7:0]    load_byte,
  input  logic          step,
  output logic [AW-1:0] ptr,
  output logic          incr
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] ptr_q, ptr_n;
  logic          incr_q, incr_n;

  always_comb begin
    ptr_n  = ptr_q;
    incr_n = incr_q;
    if (load) begin
      ptr_n  = load_byte[AW-1:0];
      incr_n = load_byte[7];
    end else if (step && incr_q) begin
      ptr_n = ptr_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      incr_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_n;
      incr_q <= incr_n;
    end
  end

  assign ptr  = ptr_q;
  assign incr = incr_q;

  // R8: fixed pointer when auto-increment is off
  p_hold_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !incr_q) |=> $stable(ptr_q));

  // R9: top register wraps to zero
  p_wrap_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && incr_q && (ptr_q == {AW{1'b1}})) |=> (ptr_q == '0));

endmodule

// File: rtl/i2ct_regs.sv
module i2ct_regs #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R5: an accepted data byte is held by the addressed register
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              ptr_load,
  output logic              ptr_step,
  output logic              wr_en,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              sda_oe
);

  eng_state_t        state_q, state_n;
  byte_kind_t        kind_q, kind_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic              rw_q, rw_n;
  logic              oe_q, oe_n;
  logic              mack_q, mack_n;

  assign rx_byte = {sh_q[BYTE_W-2:0], sda_s};

  always_comb begin
    state_n  = state_q;
    kind_n   = kind_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    rw_n     = rw_q;
    oe_n     = oe_q;
    mack_n   = mack_q;
    ptr_load = 1'b0;
    ptr_step = 1'b0;
    wr_en    = 1'b0;

    if (stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_det) begin
      state_n = ST_RXD;
      kind_n  = K_ADDR;
      cnt_n   = 4'd0;
      oe_n    = 1'b0;
    end else begin
      case (state_q)
        ST_RXD: begin
          if (scl_rise) begin
            sh_n  = rx_byte;
            cnt_n = cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              state_n = ST_ACK1;
              case (kind_q)
                K_ADDR: begin
                  if (rx_byte[7:1] == dev_addr) rw_n = rx_byte[0];
                  else                          state_n = ST_IGN;
                end
                K_PTR:   ptr_load = 1'b1;
                default: begin
                  wr_en    = 1'b1;
                  ptr_step = 1'b1;
                end
              endcase
            end
          end
        end
        ST_ACK1: begin
          if (scl_fall) begin
            oe_n    = 1'b1;
            state_n = ST_ACK2;
          end
        end
        ST_ACK2: begin
          if (scl_fall) begin
            cnt_n = 4'd0;
            if (kind_q == K_ADDR && rw_q) begin
              state_n  = ST_TX;
              oe_n     = ~rd_data[7];
              sh_n     = {rd_data[6:0], 1'b0};
              ptr_step = 1'b1;
            end else begin
              state_n = ST_RXD;
              oe_n    = 1'b0;
              kind_n  = (kind_q == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_n    = 1'b0;
              state_n = ST_MACK;
            end else begin
              oe_n = ~sh_q[7];
              sh_n = {sh_q[6:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_n  = ST_TX;
              cnt_n    = 4'd0;
              oe_n     = ~rd_data[7];
              sh_n     = {rd_data[6:0], 1'b0};
              ptr_step = 1'b1;
            end else begin
              state_n = ST_IGN;
              oe_n    = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_ADDR;
      cnt_q   <= 4'd0;
      sh_q    <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      rw_q    <= rw_n;
      oe_q    <= oe_n;
      mack_q  <= mack_n;
    end
  end

  assign sda_oe = oe_q;

  // R4: SDA is held low while the ninth clock is high
  p_ack_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACK2 && scl_rise) |-> oe_q);

  // R10: nothing is driven once the target has dropped out
  p_ignore_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGN) |-> !oe_q);

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target #(
  parameter int         REG_AW      = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_BASE    = 7'b1001010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic strap0_i,
  input  logic strap1_i
);

  import i2ct_pkg::*;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              taken_q;
  logic [1:0]        strap_q;
  logic [6:0]        dev_addr;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              ptr_load, ptr_step, wr_en, ptr_incr;
  logic [BYTE_W-1:0] rx_byte, rd_data;
  logic [REG_AW-1:0] ptr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // one-time strap capture after reset release
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      taken_q <= 1'b0;
      strap_q <= 2'b00;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      strap_q <= {strap1_i, strap0_i};
    end
  end

  assign dev_addr = DEV_BASE ^ {5'b00000, strap_q};

  i2ct_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2ct_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .dev_addr  (dev_addr),
    .rd_data   (rd_data),
    .ptr_load  (ptr_load),
    .ptr_step  (ptr_step),
    .wr_en     (wr_en),
    .rx_byte   (rx_byte),
    .sda_oe    (sda_oe_o)
  );

  i2ct_pointer #(.AW(REG_AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (ptr_load),
    .load_byte (rx_byte),
    .step      (ptr_step),
    .ptr       (ptr),
    .incr      (ptr_incr)
  );

  i2ct_regs #(.AW(REG_AW), .DW(BYTE_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (wr_en),
    .waddr (ptr),
    .wdata (rx_byte),
    .raddr (ptr),
    .rdata (rd_data)
  );

  // R2: the answered address never moves after capture
  p_addr_frozen_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(taken_q) |-> $stable(dev_addr));

  // R11: SDA drive only moves while the pad SCL is low
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(sda_oe_o) |-> !scl_i);

endmodule

// File: tb/i2c_regfile_target_test.sv
`timescale 1ns/1ps
module i2c_regfile_target_test;

  localparam int         Q    = 4;
  localparam logic [6:0] BASE = 7'b1001010;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, scl, sda_m, strap0, strap1;
  wire  sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  i2c_regfile_target uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .strap0_i (strap0),
    .strap1_i (strap1)
  );

  int checks = 0;
  int fails  = 0;
  int r11_viol = 0;
  bit done = 0;
  bit mon_en = 0;

  logic [7:0] model [128];
  logic [6:0] mptr;
  logic       minc;
  logic [6:0] cur_dev;

  function automatic logic [6:0] next_ptr(input logic [6:0] p, input logic inc);
    return inc ? p + 7'd1 : p;
  endfunction

  function automatic logic [6:0] strap_addr(input logic s1, input logic s0);
    return BASE ^ {5'b00000, s1, s0};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(2*Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    ack = ~sda_bus; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic read_byte(input logic host_ack, output logic [7:0] b);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      b = {b[6:0], sda_bus}; tick(Q);
      scl = 1'b0;   tick(Q);
    end
    send_bit(~host_ack);
  endtask

  task automatic do_reset(input logic s1, input logic s0);
    strap1 = s1; strap0 = s0;
    rst_n = 1'b0; tick(3);
    check("R11 reset: SDA released", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1; tick(8);
    mptr = 7'd0; minc = 1'b0;
    cur_dev = strap_addr(s1, s0);
  endtask

  task automatic probe(input logic [6:0] a, input logic exp_ack, input string tag);
    logic ack;
    bus_start;
    write_byte({a, 1'b0}, ack);
    bus_stop;
    check(tag, {31'd0, ack}, {31'd0, exp_ack});
  endtask

  task automatic write_txn(input logic [7:0] ptrb, input int n, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start;
    write_byte({cur_dev, 1'b0}, ack);
    check({tag, " R4 addr ack"}, {31'd0, ack}, 32'd1);
    write_byte(ptrb, ack);
    check({tag, " R4 R3 pointer ack"}, {31'd0, ack}, 32'd1);
    mptr = ptrb[6:0];
    minc = ptrb[7];
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      write_byte(d, ack);
      check({tag, " R4 R5 data ack"}, {31'd0, ack}, 32'd1);
      model[mptr] = d;
      mptr = next_ptr(mptr, minc);
    end
    bus_stop;
  endtask

  task automatic read_body(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      read_byte(i != n - 1, b);
      check({tag, " R6 read data"}, {24'd0, b}, {24'd0, model[mptr]});
      mptr = next_ptr(mptr, minc);
    end
  endtask

  task automatic read_txn(input int n, input string tag);
    logic ack;
    bus_start;
    write_byte({cur_dev, 1'b1}, ack);
    check({tag, " R4 read addr ack"}, {31'd0, ack}, 32'd1);
    read_body(n, tag);
    bus_stop;
  endtask

  task automatic rs_read(input logic [7:0] ptrb, input int n);
    logic ack;
    bus_start;
    write_byte({cur_dev, 1'b0}, ack);
    check("R12 addr ack", {31'd0, ack}, 32'd1);
    write_byte(ptrb, ack);
    check("R12 pointer ack", {31'd0, ack}, 32'd1);
    mptr = ptrb[6:0];
    minc = ptrb[7];
    bus_start;
    write_byte({cur_dev, 1'b1}, ack);
    check("R12 addr ack after repeated START", {31'd0, ack}, 32'd1);
    read_body(n, "R12");
    bus_stop;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // R11 watcher: drive may not move while SCL is high
  logic oe_d = 1'b0;
  always @(negedge clk) begin
    if (mon_en && (sda_oe !== oe_d) && scl) r11_viol++;
    oe_d <= sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run;
  end

  initial begin
    logic ack;
    logic [1:0] op;
    void'($urandom(32'd2024));
    scl = 1'b1; sda_m = 1'b1;
    do_reset(1'b0, 1'b0);
    mon_en = 1;

    // R1: default address with straps low
    probe(BASE, 1'b1, "R1 default address acked");
    probe(BASE ^ 7'd1, 1'b0, "R1 neighbour address not acked");

    // R2: strap changes after reset have no effect
    strap1 = 1'b1; strap0 = 1'b1; tick(5);
    probe(BASE, 1'b1, "R2 captured address still acked");
    probe(BASE ^ 7'd3, 1'b0, "R2 new strap address ignored");

    // R1: strap0 flips bit 0 when captured at reset
    do_reset(1'b0, 1'b1);
    probe(7'b1001011, 1'b1, "R1 strap0 address acked");
    probe(BASE, 1'b0, "R1 default no longer acked");
    do_reset(1'b1, 1'b0);
    probe(7'b1001000, 1'b1, "R1 strap1 address acked");
    do_reset(1'b0, 1'b0);

    // fill all registers (R9: pointer wraps back to 0)
    write_txn(8'h80, 128, "fill");

    // R3 R5 R7: write three, pointer-only preamble, read back
    write_txn(8'h85, 3, "R5");
    write_txn(8'h85, 0, "R7 preamble");
    read_txn(3, "R7");
    read_txn(2, "R6 pointer carried over");

    // R8: fixed pointer
    write_txn(8'h10, 3, "R8");
    write_txn(8'h10, 0, "R8 preamble");
    read_txn(3, "R8 repeated register");
    write_txn(8'h91, 0, "R8 neighbour preamble");
    read_txn(1, "R8 neighbour untouched");

    // R9: wrap on write and read
    write_txn(8'hFE, 3, "R9");
    write_txn(8'hFE, 0, "R9 preamble");
    read_txn(4, "R9 wrap");

    // R12: repeated START keeps pointer
    rs_read(8'h83, 3);

    // R10: mismatched address, later bytes not acked, state untouched
    bus_start;
    write_byte({BASE ^ 7'd2, 1'b0}, ack);
    check("R10 mismatch address ack", {31'd0, ack}, 32'd0);
    write_byte(8'h05, ack);
    check("R10 later byte not acked", {31'd0, ack}, 32'd0);
    write_byte(8'hA5, ack);
    check("R10 data byte not acked", {31'd0, ack}, 32'd0);
    bus_stop;
    read_txn(2, "R10 pointer and data unchanged");

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      op = 2'($urandom_range(0, 2));
      case (op)
        2'd0: write_txn(8'($urandom), $urandom_range(1, 5), "rand R5");
        2'd1: write_txn(8'($urandom), 0, "rand R7");
        default: read_txn($urandom_range(1, 4), "rand R6");
      endcase
    end
    rs_read(8'($urandom) | 8'h80, 2);

    mon_en = 0;
    check("R11 SDA never moved with SCL high", r11_viol, 32'd0);
    tick(10);
    finish_run;
  end

endmodule